// File: doc/BRIEF.md
# Chained Descriptor DMA Engine

This block is a single-channel DMA engine that moves a byte stream between system memory and a peripheral FIFO. Software builds a linked list of descriptors in memory, writes the address of the first one into the descriptor pointer register, selects a direction and sets the run bit. The engine then fetches each descriptor, moves the number of bytes it names, follows its branch address to the next one, and stops after the descriptor that carries the end flag.

Each transfer ends with a 4-bit outcome code in the channel control register: success, descriptor fetch failure, data access failure or an early end signalled by the peripheral. Every outcome clears the run bit and sets the interrupt status bit. The interrupt output is that bit gated by the interrupt enable bit. A soft reset through the global control register abandons any transfer at once.

Registers sit on a 32-bit word port: byte offset 0x00 global control, 0x04 interrupt enable, 0x08 interrupt status, 0x0C descriptor pointer, 0x10 channel control. Memory is reached through a single-outstanding request/acknowledge port, and the peripheral through byte-wide valid/ready streams.

Top module: `dmac_chain`

## Requirements
- R1: After reset every register reads 0, irq is 0 and mem_req, tx_valid and rx_ready are all 0.
- R2: Global control bit 0 is the enable and reads back as written; bit 8 written as 1 is the soft reset and reads 0. A run request written while the enable is 0 leaves the run bit at 0.
- R3: A descriptor is four little-endian 32-bit words at ptr, ptr+4, ptr+8, ptr+12: flags, buffer address, branch address and an unused word. In flags, bit 31 is the end flag, bit 30 must be 1, and bits 15:0 are the byte count. Descriptors are processed in branch order until one with the end flag completes.
- R4: With channel control bit 22 at 0 (memory to peripheral), the bytes at buffer, buffer+1, ... are presented on tx_data in ascending order, one memory read per byte, the byte taken from lane mem_addr[1:0] of mem_rdata.
- R5: With bit 22 at 1 (peripheral to memory), each accepted rx byte is written to the next ascending buffer address with exactly one mem_wstrb bit set, bit mem_addr[1:0], and the byte repeated on all four lanes of mem_wdata.
- R6: When the end descriptor finishes, channel control bits 3:0 become 0xF, run (bit 7) clears and interrupt status bit 0 sets; while run is 0 the engine makes no memory request and no stream handshake.
- R7: irq is interrupt status bit 0 AND interrupt enable bit 0. Writing 1 to status bit 0 clears it, writing 0 leaves it.
- R8: If rx_last comes with a byte other than the final byte of the end descriptor, that byte is written and the transfer stops with code 5; no later address is written.
- R9: An error response to a descriptor fetch, or a fetched flags word with bit 30 at 0, stops with code 3; an error response to a data access stops with code 4. Each error clears run and sets interrupt status.
- R10: A write to channel control while run is 1 is ignored, including its direction bit.
- R11: A soft reset clears every register and ends any transfer in the next cycle: mem_req, tx_valid, rx_ready and irq drop to 0.
- R12: A memory request stays asserted with a stable address until mem_ack, and at most one of mem_req, tx_valid and rx_ready is high at a time.
- R13: tx_valid, once high, stays high with tx_data unchanged until tx_ready accepts the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_wstrb | output | 4 | Memory write byte strobes |
| mem_ack | input | 1 | Memory response strobe |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_err | input | 1 | Error response, valid with mem_ack |
| tx_valid | output | 1 | Byte toward peripheral is valid |
| tx_ready | input | 1 | Peripheral accepts the byte |
| tx_data | output | 8 | Byte toward peripheral |
| rx_valid | input | 1 | Byte from peripheral is valid |
| rx_ready | output | 1 | Engine accepts a byte |
| rx_data | input | 8 | Byte from peripheral |
| rx_last | input | 1 | Peripheral has no more data after this byte |

## Verification
The assertions watch, on every cycle, the memory and stream handshakes holding steady until accepted, the single active port, the single write strobe, the quiet engine while run is 0, the legal outcome codes, run and status after each completion, the ignored channel write during a transfer, and the effect of soft reset. Only the bench scenarios show that bytes come out in the right order across a chain of descriptors with odd lengths and unaligned buffers, that rx data lands at the right addresses, and that early end, fetch and data errors and the format check each give their own code with no stray writes.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
package dmac_pkg;

  typedef enum logic [3:0] {
    OC_NONE     = 4'h0,
    OC_UNDERRUN = 4'h1,
    OC_OVERRUN  = 4'h2,
    OC_DESC_ERR = 4'h3,
    OC_DATA_ERR = 4'h4,
    OC_EARLY    = 4'h5,
    OC_DONE     = 4'hF
  } outcome_e;

  typedef enum logic [2:0] {
    WK_IDLE, WK_FETCH, WK_RD, WK_TX, WK_RX, WK_WR
  } walk_state_e;

  localparam int FL_END_BIT = 31;
  localparam int FL_FMT_BIT = 30;
  localparam int CH_RUN_BIT = 7;
  localparam int CH_DIR_BIT = 22;
  localparam int GC_EN_BIT  = 0;
  localparam int GC_RST_BIT = 8;

  localparam logic [2:0] RIX_GLOBAL = 3'd0;
  localparam logic [2:0] RIX_IEN    = 3'd1;
  localparam logic [2:0] RIX_ISTAT  = 3'd2;
  localparam logic [2:0] RIX_DPTR   = 3'd3;
  localparam logic [2:0] RIX_CHAN   = 3'd4;

  function automatic logic [7:0] pick_lane(input logic [31:0] w, input logic [1:0] off);
    return w[8*off +: 8];
  endfunction

  function automatic logic [3:0] lane_strobe(input logic [1:0] off);
    return 4'b0001 << off;
  endfunction

  function automatic logic flag_end(input logic [31:0] f);
    return f[FL_END_BIT];
  endfunction

  function automatic logic flag_fmt_ok(input logic [31:0] f);
    return f[FL_FMT_BIT];
  endfunction

  function automatic logic [31:0] chan_word(input logic dir, input logic run,
                                            input logic [3:0] code);
    logic [31:0] w;
    w = '0;
    w[CH_DIR_BIT] = dir;
    w[CH_RUN_BIT] = run;
    w[3:0] = code;
    return w;
  endfunction

endpackage

// File: rtl/dmac_regs.sv
`timescale 1ns/1ps
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int RAW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [RAW-1:0] addr,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata,
  input  logic           fin_valid,
  input  logic [3:0]     fin_code,
  output logic           start,
  output logic           srst,
  output logic           ch_wr,
  output logic [31:0]    desc_ptr,
  output logic           dir_bit,
  output logic           run_bit,
  output logic           is_bit,
  output logic           irq
);
  logic       en_q, ie_q;
  logic [3:0] code_q;
  logic [2:0] rix;
  logic       g_wr, ie_wr, is_wr, ptr_wr;

  assign rix    = addr[4:2];
  assign g_wr   = we && (rix == RIX_GLOBAL);
  assign ie_wr  = we && (rix == RIX_IEN);
  assign is_wr  = we && (rix == RIX_ISTAT);
  assign ptr_wr = we && (rix == RIX_DPTR);
  assign ch_wr  = we && (rix == RIX_CHAN);
  assign srst   = g_wr && wdata[GC_RST_BIT];
  assign start  = ch_wr && !run_bit && en_q && wdata[CH_RUN_BIT];
  assign irq    = ie_q && is_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; ie_q <= 1'b0; is_bit <= 1'b0; desc_ptr <= '0;
      run_bit <= 1'b0; dir_bit <= 1'b0; code_q <= OC_NONE;
    end else if (srst) begin
      en_q <= 1'b0; ie_q <= 1'b0; is_bit <= 1'b0; desc_ptr <= '0;
      run_bit <= 1'b0; dir_bit <= 1'b0; code_q <= OC_NONE;
    end else begin
      if (g_wr)   en_q <= wdata[GC_EN_BIT];
      if (ie_wr)  ie_q <= wdata[0];
      if (ptr_wr) desc_ptr <= wdata;
      if (fin_valid) begin
        is_bit  <= 1'b1;
        run_bit <= 1'b0;
        code_q  <= fin_code;
      end else if (is_wr && wdata[0]) begin
        is_bit <= 1'b0;
      end
      if (start) begin
        run_bit <= 1'b1;
        code_q  <= OC_NONE;
        dir_bit <= wdata[CH_DIR_BIT];
      end else if (ch_wr && !run_bit) begin
        dir_bit <= wdata[CH_DIR_BIT];
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (rix)
      RIX_GLOBAL: rdata[GC_EN_BIT] = en_q;
      RIX_IEN:    rdata[0] = ie_q;
      RIX_ISTAT:  rdata[0] = is_bit;
      RIX_DPTR:   rdata = desc_ptr;
      RIX_CHAN:   rdata = chan_word(dir_bit, run_bit, code_q);
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/dmac_walker.sv
`timescale 1ns/1ps
module dmac_walker
  import dmac_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          start,
  input  logic [31:0]   start_ptr,
  input  logic          start_dir,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_wstrb,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_err,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  output logic          fin_valid,
  output logic [3:0]    fin_code
);
  walk_state_e   st_q;
  logic [AW-1:0] cur_q, buf_q, br_q;
  logic [1:0]    wi_q;
  logic [CW-1:0] cnt_q, idx_q, idx_nx;
  logic          end_q, fmt_q, dir_q, last_q;
  logic [7:0]    byte_q;
  logic          last_byte, desc_empty;

  assign idx_nx     = idx_q + 1'b1;
  assign last_byte  = (idx_nx == cnt_q);
  assign desc_empty = (cnt_q == '0);

  assign mem_req   = (st_q == WK_FETCH) || (st_q == WK_RD) || (st_q == WK_WR);
  assign mem_we    = (st_q == WK_WR);
  assign mem_addr  = (st_q == WK_FETCH) ? cur_q + AW'({wi_q, 2'b00})
                                        : buf_q + AW'(idx_q);
  assign mem_wdata = {4{byte_q}};
  assign mem_wstrb = (st_q == WK_WR) ? lane_strobe(mem_addr[1:0]) : 4'b0000;
  assign tx_valid  = (st_q == WK_TX);
  assign tx_data   = byte_q;
  assign rx_ready  = (st_q == WK_RX);

  always_comb begin
    fin_valid = 1'b0;
    fin_code  = OC_NONE;
    case (st_q)
      WK_FETCH: if (mem_ack) begin
        if (mem_err || (wi_q == 2'd2 && !fmt_q)) begin
          fin_valid = 1'b1; fin_code = OC_DESC_ERR;
        end else if (wi_q == 2'd2 && desc_empty && end_q) begin
          fin_valid = 1'b1; fin_code = OC_DONE;
        end
      end
      WK_RD: if (mem_ack && mem_err) begin
        fin_valid = 1'b1; fin_code = OC_DATA_ERR;
      end
      WK_TX: if (tx_ready && last_byte && end_q) begin
        fin_valid = 1'b1; fin_code = OC_DONE;
      end
      WK_WR: if (mem_ack) begin
        if (mem_err) begin
          fin_valid = 1'b1; fin_code = OC_DATA_ERR;
        end else if (last_byte && end_q) begin
          fin_valid = 1'b1; fin_code = OC_DONE;
        end else if (last_q) begin
          fin_valid = 1'b1; fin_code = OC_EARLY;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= WK_IDLE; cur_q <= '0; buf_q <= '0; br_q <= '0; wi_q <= '0;
      cnt_q <= '0; idx_q <= '0; end_q <= 1'b0; fmt_q <= 1'b0;
      dir_q <= 1'b0; last_q <= 1'b0; byte_q <= '0;
    end else if (abort || fin_valid) begin
      st_q <= WK_IDLE;
    end else begin
      case (st_q)
        WK_IDLE: if (start) begin
          cur_q <= AW'(start_ptr);
          dir_q <= start_dir;
          wi_q  <= 2'd0;
          st_q  <= WK_FETCH;
        end
        WK_FETCH: if (mem_ack) begin
          case (wi_q)
            2'd0: begin
              cnt_q <= mem_rdata[CW-1:0];
              end_q <= flag_end(mem_rdata);
              fmt_q <= flag_fmt_ok(mem_rdata);
              wi_q  <= 2'd1;
            end
            2'd1: begin
              buf_q <= AW'(mem_rdata);
              wi_q  <= 2'd2;
            end
            default: begin
              br_q  <= AW'(mem_rdata);
              idx_q <= '0;
              if (desc_empty) begin
                cur_q <= AW'(mem_rdata);
                wi_q  <= 2'd0;
              end else begin
                st_q <= dir_q ? WK_RX : WK_RD;
              end
            end
          endcase
        end
        WK_RD: if (mem_ack) begin
          byte_q <= pick_lane(mem_rdata, mem_addr[1:0]);
          st_q   <= WK_TX;
        end
        WK_TX: if (tx_ready) begin
          idx_q <= idx_nx;
          if (last_byte) begin
            cur_q <= br_q; wi_q <= 2'd0; st_q <= WK_FETCH;
          end else begin
            st_q <= WK_RD;
          end
        end
        WK_RX: if (rx_valid) begin
          byte_q <= rx_data;
          last_q <= rx_last;
          st_q   <= WK_WR;
        end
        WK_WR: if (mem_ack) begin
          idx_q <= idx_nx;
          if (last_byte) begin
            cur_q <= br_q; wi_q <= 2'd0; st_q <= WK_FETCH;
          end else begin
            st_q <= WK_RX;
          end
        end
        default: st_q <= WK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmac_chain.sv
`timescale 1ns/1ps
module dmac_chain
  import dmac_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int RAW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           irq,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [31:0]    mem_wdata,
  output logic [3:0]     mem_wstrb,
  input  logic           mem_ack,
  input  logic [31:0]    mem_rdata,
  input  logic           mem_err,
  output logic           tx_valid,
  input  logic           tx_ready,
  output logic [7:0]     tx_data,
  input  logic           rx_valid,
  output logic           rx_ready,
  input  logic [7:0]     rx_data,
  input  logic           rx_last
);
  logic        start, srst, ch_wr, dir_bit, run_bit, is_bit;
  logic        fin_valid;
  logic [3:0]  fin_code;
  logic [31:0] desc_ptr;

  dmac_regs #(.RAW(RAW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .fin_valid(fin_valid), .fin_code(fin_code),
    .start(start), .srst(srst), .ch_wr(ch_wr), .desc_ptr(desc_ptr),
    .dir_bit(dir_bit), .run_bit(run_bit), .is_bit(is_bit), .irq(irq)
  );

  dmac_walker #(.AW(AW), .CW(CW)) u_walk (
    .clk(clk), .rst_n(rst_n), .abort(srst), .start(start),
    .start_ptr(desc_ptr), .start_dir(reg_wdata[CH_DIR_BIT]),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .mem_err(mem_err),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_last(rx_last), .fin_valid(fin_valid), .fin_code(fin_code)
  );
endmodule

// File: rtl/dmac_chain_chk.sv
`timescale 1ns/1ps
module dmac_chain_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_wstrb,
  input logic          mem_ack,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          rx_ready,
  input logic          irq,
  input logic          srst,
  input logic          ch_wr,
  input logic          run_bit,
  input logic          dir_bit,
  input logic          is_bit,
  input logic          fin_valid,
  input logic [3:0]    fin_code
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !srst) |=> (mem_req && $stable(mem_addr))); // R12
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req, tx_valid, rx_ready})); // R12
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !srst) |=> (tx_valid && $stable(tx_data))); // R13
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ($countones(mem_wstrb) == 1)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_bit |-> (!mem_req && !tx_valid && !rx_ready)); // R6
  AST_FIN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_valid && !srst) |=> (is_bit && !run_bit)); // R6
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    fin_valid |-> (fin_code == 4'h3 || fin_code == 4'h4 ||
                   fin_code == 4'h5 || fin_code == 4'hF)); // R9
  AST_RUN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (run_bit && ch_wr && !fin_valid && !srst) |=> (run_bit && $stable(dir_bit))); // R10
  AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!run_bit && !mem_req && !tx_valid && !rx_ready && !irq)); // R11
endmodule

bind dmac_chain dmac_chain_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wstrb(mem_wstrb), .mem_ack(mem_ack),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .rx_ready(rx_ready), .irq(irq), .srst(srst), .ch_wr(ch_wr),
  .run_bit(run_bit), .dir_bit(dir_bit), .is_bit(is_bit),
  .fin_valid(fin_valid), .fin_code(fin_code)
);

// File: tb/dmac_chain_tb.sv
`timescale 1ns/1ps
module dmac_chain_tb;
  localparam logic [4:0] A_GC = 5'h00, A_IE = 5'h04, A_IS = 5'h08,
                         A_DP = 5'h0C, A_CH = 5'h10;
  localparam logic [31:0] F_END = 32'h8000_0000, F_FMT = 32'h4000_0000;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [4:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, mem_req, mem_we, mem_ack = 0, mem_err = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic [3:0] mem_wstrb;
  logic tx_valid, tx_ready, rx_valid = 0, rx_ready, rx_last = 0;
  logic [7:0] tx_data, rx_data = 0;

  always #2.5 clk = ~clk;

  dmac_chain u_dut (.*);

  logic [7:0] mem [0:1023];
  int err_lo = 2000, err_hi = 2000;
  int compared = 0, mismatched = 0, cyc = 0, req_viol = 0;
  bit tx_hold = 0, tx_throttle = 0, done_flag = 0;
  logic [7:0]  exp_tx[$];
  logic [17:0] exp_wr[$];

  assign tx_ready = !tx_hold && (!tx_throttle || cyc[0]);

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // memory model: one-cycle acknowledge
  initial forever begin
    @(posedge clk);
    cyc <= cyc + 1;
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      automatic int a = int'(mem_addr[9:0]);
      automatic bit bad = (int'(mem_addr) >= err_lo) && (int'(mem_addr) <= err_hi);
      mem_ack <= 1'b1;
      mem_err <= bad;
      if (mem_we) begin
        for (int k = 0; k < 4; k++)
          if (mem_wstrb[k] && !bad) mem[(a & ~3) + k] = mem_wdata[8*k +: 8];
      end else begin
        mem_rdata <= {mem[(a & ~3) + 3], mem[(a & ~3) + 2], mem[(a & ~3) + 1], mem[a & ~3]};
      end
    end
  end

  // scoreboard monitor
  initial begin
    automatic bit pend = 0;
    automatic logic [31:0] paddr = 0;
    forever begin
      @(negedge clk);
      if (pend && mem_req && mem_addr != paddr) req_viol++;
      pend = mem_req && !mem_ack;
      paddr = mem_addr;
      if (rst_n && tx_valid && tx_ready) begin
        if (exp_tx.size() == 0) check(0, "R4 unexpected tx byte", {24'b0, tx_data}, 0);
        else begin
          automatic logic [7:0] e = exp_tx.pop_front();
          check(tx_data == e, "R4 tx byte order", {24'b0, tx_data}, {24'b0, e});
        end
      end
      if (rst_n && mem_req && mem_we && mem_ack && !mem_err) begin
        automatic logic [1:0] ln = mem_addr[1:0];
        automatic logic [17:0] got = {mem_addr[9:0], mem_wdata[8*ln +: 8]};
        check(mem_wstrb == (4'b1 << ln), "R5 write strobe", {28'b0, mem_wstrb}, {28'b0, 4'b1 << ln});
        if (exp_wr.size() == 0) check(0, "R5 unexpected write", {14'b0, got}, 0);
        else begin
          automatic logic [17:0] e = exp_wr.pop_front();
          check(got == e, "R5 write addr/data", {14'b0, got}, {14'b0, e});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++; compared++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic put_word(input int a, input logic [31:0] w);
    for (int k = 0; k < 4; k++) mem[a + k] = w[8*k +: 8];
  endtask

  task automatic put_desc(input int a, input logic [31:0] fl, input int bufa, input int br);
    put_word(a, fl); put_word(a + 4, bufa); put_word(a + 8, br); put_word(a + 12, 32'hDEAD_BEEF);
  endtask

  task automatic push_tx(input int a, input int n);
    for (int k = 0; k < n; k++) exp_tx.push_back(mem[a + k]);
  endtask

  task automatic run(input int ptr, input bit dir);
    reg_wr(A_DP, ptr);
    reg_wr(A_CH, (32'(dir) << 22) | 32'h80);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      reg_rd(A_CH, v);
      if (!v[7]) return;
    end
  endtask

  task automatic send_rx(input logic [7:0] b, input bit last, input int a);
    exp_wr.push_back({10'(a), b});
    @(negedge clk); rx_valid = 1; rx_data = b; rx_last = last;
    while (!rx_ready) @(negedge clk);
    @(negedge clk); rx_valid = 0; rx_last = 0;
  endtask

  logic [31:0] v;
  logic [7:0] d0, keep;

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    reg_rd(A_GC, v); check(v == 0, "R1 global", v, 0);
    reg_rd(A_IS, v); check(v == 0, "R1 int status", v, 0);
    reg_rd(A_CH, v); check(v == 0, "R1 channel", v, 0);
    check({irq, mem_req, tx_valid, rx_ready} == 0, "R1 outputs", {irq, mem_req, tx_valid, rx_ready}, 0);

    // R2 run ignored while disabled
    run(32'h140, 0);
    reg_rd(A_CH, v); check(v[7] == 0, "R2 run while disabled", v, 0);
    reg_wr(A_GC, 1);
    reg_rd(A_GC, v); check(v == 1, "R2 enable readback", v, 1);

    // R3 R4 R6 tx chain with throttled peripheral
    put_desc(32'h140, F_FMT | 5, 32'h203, 32'h100);
    put_desc(32'h100, F_FMT | 1, 32'h251, 32'h180);
    put_desc(32'h180, F_END | F_FMT | 7, 32'h2A6, 32'h3F0);
    push_tx(32'h203, 5); push_tx(32'h251, 1); push_tx(32'h2A6, 7);
    reg_wr(A_IE, 1);
    tx_throttle = 1;
    run(32'h140, 0);
    wait_idle();
    check(exp_tx.size() == 0, "R3 chain fully sent", exp_tx.size(), 0);
    reg_rd(A_CH, v); check(v == 32'hF, "R6 success code", v, 32'hF);
    reg_rd(A_IS, v); check(v == 1, "R6 int status set", v, 1);
    check(irq == 1, "R7 irq with enable", irq, 1);

    // R7 status clear and gating
    reg_wr(A_IS, 0); reg_rd(A_IS, v); check(v == 1, "R7 write 0 keeps status", v, 1);
    reg_wr(A_IE, 0); #1 check(irq == 0, "R7 irq gated", irq, 0);
    reg_wr(A_IE, 1); reg_wr(A_IS, 1); reg_rd(A_IS, v);
    check(v == 0 && irq == 0, "R7 write 1 clears", {v[30:0], irq}, 0);

    // R5 rx chain
    tx_throttle = 0;
    put_desc(32'h1C0, F_FMT | 3, 32'h301, 32'h1E0);
    put_desc(32'h1E0, F_END | F_FMT | 4, 32'h312, 32'h000);
    run(32'h1C0, 1);
    for (int k = 0; k < 3; k++) send_rx(8'hA0 + 8'(k), 0, 32'h301 + k);
    for (int k = 0; k < 4; k++) send_rx(8'hB0 + 8'(k), k == 3, 32'h312 + k);
    wait_idle();
    reg_rd(A_CH, v); check(v == 32'h0040_000F, "R5 rx success", v, 32'h0040_000F);
    check(mem[32'h313] == 8'hB1, "R5 memory byte", mem[32'h313], 8'hB1);
    check(exp_wr.size() == 0, "R5 all writes seen", exp_wr.size(), 0);

    // R8 early end
    reg_wr(A_IS, 1);
    put_desc(32'h1C0, F_END | F_FMT | 6, 32'h330, 32'h000);
    keep = mem[32'h333];
    run(32'h1C0, 1);
    for (int k = 0; k < 3; k++) send_rx(8'hC0 + 8'(k), k == 2, 32'h330 + k);
    wait_idle();
    reg_rd(A_CH, v); check(v[3:0] == 4'h5, "R8 early end code", v, 5);
    check(mem[32'h333] == keep, "R8 no write past end", mem[32'h333], keep);
    reg_rd(A_IS, v); check(v == 1, "R8 status set", v, 1);

    // R9 errors
    reg_wr(A_IS, 1);
    err_lo = 32'h3C0; err_hi = 32'h3CF;
    run(32'h3C0, 0); wait_idle();
    reg_rd(A_CH, v); check(v[3:0] == 4'h3, "R9 fetch error", v, 3);
    put_desc(32'h1A0, F_END | 4, 32'h220, 32'h000);
    run(32'h1A0, 0); wait_idle();
    reg_rd(A_CH, v); check(v[3:0] == 4'h3, "R9 format bit clear", v, 3);
    put_desc(32'h1A0, F_END | F_FMT | 4, 32'h3C2, 32'h000);
    run(32'h1A0, 0); wait_idle();
    reg_rd(A_CH, v); check(v == 32'h4, "R9 data error", v, 4);
    reg_rd(A_IS, v); check(v == 1, "R9 status set", v, 1);
    check(exp_tx.size() == 0, "R9 no tx bytes", exp_tx.size(), 0);
    err_lo = 2000; err_hi = 2000;

    // R10 channel write during transfer ignored
    reg_wr(A_IS, 1);
    tx_throttle = 1;
    push_tx(32'h203, 5); push_tx(32'h251, 1); push_tx(32'h2A6, 7);
    run(32'h140, 0);
    reg_wr(A_CH, 32'h0040_0080);
    reg_rd(A_CH, v); check(v[22] == 0 && v[7] == 1, "R10 dir kept while running", v, 32'h80);
    wait_idle();
    reg_rd(A_CH, v); check(v == 32'hF, "R10 transfer unchanged", v, 32'hF);
    check(exp_tx.size() == 0, "R10 all bytes sent", exp_tx.size(), 0);

    // R11 R13 soft reset with peripheral stalled
    tx_throttle = 0; tx_hold = 1;
    run(32'h140, 0);
    repeat (10) @(negedge clk);
    d0 = tx_data;
    check(tx_valid == 1, "R13 byte offered", tx_valid, 1);
    repeat (5) @(negedge clk);
    check(tx_valid == 1 && tx_data == d0, "R13 byte held", {23'b0, tx_valid, tx_data}, {23'b0, 1'b1, d0});
    reg_wr(A_GC, 32'h100);
    check({mem_req, tx_valid, rx_ready, irq} == 0, "R11 outputs idle", {mem_req, tx_valid, rx_ready, irq}, 0);
    reg_rd(A_CH, v); check(v == 0, "R11 channel cleared", v, 0);
    reg_rd(A_GC, v); check(v == 0, "R11 enable cleared", v, 0);
    reg_rd(A_DP, v); check(v == 0, "R11 pointer cleared", v, 0);
    exp_tx.delete();
    tx_hold = 0;
    repeat (4) @(negedge clk);
    check(req_viol == 0, "R12 request held until ack", req_viol, 0);
    summary();
  end
endmodule